// File: doc/BRIEF.md
# Synchronous SRAM Read Output Controller

This block sits between the storage array of a synchronous burst SRAM and its data pins. Every rising clock edge it captures one command (read, write or deselect). For each read it takes the array word that arrives in the cycle after capture and presents it on the output bus. It also decides, cycle by cycle, whether the output drivers are enabled.

Two static mode inputs shape the timing. The first chooses between flow-through delivery and a registered pipeline stage. The second chooses how long the drivers stay on after a deselect: single-cycle or dual-cycle. Both mode inputs pass through an internal mode register that reloads only while no read is in flight. An asynchronous active-low output enable and an asynchronous active-high sleep input gate the drivers directly. While sleep is high, commands are ignored.

Top module: `sram_rdout_ctl`

## Requirements
- R1: Pipeline mode (registered mode bit 1): a read captured at edge k takes the array word present on `rdata_i` between edges k and k+1. The block drives that word on `dq_o` with `dq_oe_o` high from edge k+1 until edge k+2, which gives a 3-1-1-1 burst.
- R2: Flow-through mode (registered mode bit 0): a read captured at edge k drives `rdata_i` combinationally on `dq_o` with `dq_oe_o` high from edge k until edge k+1, which gives a 2-1-1-1 burst.
- R3: Single-cycle deselect: the drivers switch off in the first slot that holds no read. In flow-through mode this is right after the deselect edge. In pipeline mode it is one edge later.
- R4: Dual-cycle deselect: when a deselect directly follows a read, the drivers stay on for one more slot and repeat the last read word, then switch off.
- R5: `cmd_i` encodes 2'b01 read, 2'b10 write, and 2'b00 or 2'b11 deselect. The slot a write occupies never drives the bus, in either mode. No dual-cycle extension follows a write.
- R6: `dq_oe_o` is low at any moment `oe_n_i` is high, and it follows `oe_n_i` without waiting for a clock edge.
- R7: `dq_oe_o` is low at any moment `sleep_i` is high. A command captured while `sleep_i` is high is treated as a deselect.
- R8: A synchronous reset clears the command history and the output register and turns the drivers off. It loads the mode register with pipeline and single-cycle deselect, whatever the mode inputs are.
- R9: The mode register reloads from `pipe_sel_i` and `dcd_sel_i` only at an edge where neither the incoming command nor any of the three previously captured commands is a read. A mode change made during a burst therefore takes effect only after the burst has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 2 | Command captured each edge (01 read, 10 write, else deselect) |
| rdata_i | input | DW | Array word for the read captured at the previous edge |
| pipe_sel_i | input | 1 | 1 selects registered pipeline output, 0 flow-through |
| dcd_sel_i | input | 1 | 1 selects dual-cycle deselect, 0 single-cycle |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous sleep, active high |
| dq_o | output | DW | Output data word |
| dq_oe_o | output | 1 | Output driver enable |

## Verification
The main function is tried with back-to-back read pairs under each of the four mode combinations, so first-word latency, burst spacing and switch-off time can be compared between flow-through and pipeline, and between single-cycle and dual-cycle deselect. A read–write–read pattern checks that a write slot stays off even between two reads. Junk array words placed on `rdata_i` during slots that must not drive show whether the held word or the live input reaches the bus. A mode change issued in the middle of a burst shows whether the old timing survives until the pipeline drains. Directed cases then toggle the enable and sleep inputs mid-cycle, issue a read during sleep, and issue a read right after reset with the mode inputs set against the defaults.

// File: rtl/sram_rdout_ctl.sv
module sram_rdout_ctl #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cmd_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          pipe_sel_i,
  input  logic          dcd_sel_i,
  input  logic          oe_n_i,
  input  logic          sleep_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  localparam logic [1:0] C_DES = 2'b00;
  localparam logic [1:0] C_RD  = 2'b01;
  localparam logic [1:0] C_WR  = 2'b10;

  logic [1:0]    cap, s1, s2, s3;
  logic [DW-1:0] oreg;
  logic          pipe_q, dcd_q;
  logic          idle, drv_ft, drv_pp, drive;

  assign cap = sleep_i          ? C_DES :
               (cmd_i == C_RD)  ? C_RD  :
               (cmd_i == C_WR)  ? C_WR  : C_DES;

  assign idle = (cap != C_RD) && (s1 != C_RD) && (s2 != C_RD) && (s3 != C_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= C_DES;
      s2     <= C_DES;
      s3     <= C_DES;
      oreg   <= '0;
      pipe_q <= 1'b1;
      dcd_q  <= 1'b0;
    end else begin
      s1 <= cap;
      s2 <= s1;
      s3 <= s2;
      if (s1 == C_RD) oreg <= rdata_i;
      if (idle) begin
        pipe_q <= pipe_sel_i;
        dcd_q  <= dcd_sel_i;
      end
    end
  end

  assign drv_ft = (s1 == C_RD) || (dcd_q && (s1 == C_DES) && (s2 == C_RD));
  assign drv_pp = (s2 == C_RD) || (dcd_q && (s2 == C_DES) && (s3 == C_RD));
  assign drive  = pipe_q ? drv_pp : drv_ft;

  assign dq_o    = (!pipe_q && (s1 == C_RD)) ? rdata_i : oreg;
  assign dq_oe_o = drive && !oe_n_i && !sleep_i;
endmodule

// File: rtl/sram_rdout_ctl_chk.sv
module sram_rdout_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cmd_i,
  input logic       oe_n_i,
  input logic       sleep_i,
  input logic       dq_oe_o,
  input logic       pipe_q,
  input logic       dcd_q
);
  p_pipe_slot_r1: assert property (@(posedge clk) disable iff (rst)
    (pipe_q && !$past(rst) && !$past(rst, 2) && $past(cmd_i, 2) == 2'b01 && !$past(sleep_i, 2))
      |-> (dq_oe_o == (!oe_n_i && !sleep_i)));

  p_ft_scd_off_r3: assert property (@(posedge clk) disable iff (rst)
    (!pipe_q && !dcd_q && !$past(rst) && $past(cmd_i) != 2'b01) |-> !dq_oe_o);

  p_write_gap_ft_r5: assert property (@(posedge clk) disable iff (rst)
    (!pipe_q && !$past(rst) && $past(cmd_i) == 2'b10 && !$past(sleep_i)) |-> !dq_oe_o);

  p_write_gap_pp_r5: assert property (@(posedge clk) disable iff (rst)
    (pipe_q && !$past(rst) && !$past(rst, 2) && $past(cmd_i, 2) == 2'b10 && !$past(sleep_i, 2))
      |-> !dq_oe_o);

  p_oe_gate_r6: assert property (@(posedge clk) disable iff (rst)
    oe_n_i |-> !dq_oe_o);

  p_sleep_off_r7: assert property (@(posedge clk) disable iff (rst)
    sleep_i |-> !dq_oe_o);

  p_reset_off_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dq_oe_o && pipe_q && !dcd_q));

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmd_i) == 2'b01 && !$past(sleep_i)) |-> ($stable(pipe_q) && $stable(dcd_q)));
endmodule

bind sram_rdout_ctl sram_rdout_ctl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cmd_i   (cmd_i),
  .oe_n_i  (oe_n_i),
  .sleep_i (sleep_i),
  .dq_oe_o (dq_oe_o),
  .pipe_q  (pipe_q),
  .dcd_q   (dcd_q)
);

// File: tb/sram_rdout_ctl_bench.sv
`timescale 1ns/1ps
module sram_rdout_ctl_bench;
  localparam int DW = 36;
  localparam logic [1:0] D = 2'b00, R = 2'b01, W = 2'b10;

  typedef struct packed {
    logic       pipe;
    logic       dcd;
    logic [1:0] cmd;
    logic [7:0] rd;
    logic       oe;
    logic [7:0] dq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,R,8'h00,1'b0,8'h00,4'd8},  // 0  R8 default mode, pipeline SCD
    '{1'b1,1'b0,R,8'hA1,1'b0,8'h00,4'd1},  // 1  R1 no data yet
    '{1'b1,1'b0,D,8'hA2,1'b1,8'hA1,4'd1},  // 2  R1 first word
    '{1'b1,1'b0,D,8'h00,1'b1,8'hA2,4'd1},  // 3  R1 second word
    '{1'b1,1'b0,D,8'h00,1'b0,8'h00,4'd3},  // 4  R3 off
    '{1'b0,1'b0,D,8'h00,1'b0,8'h00,4'd3},  // 5
    '{1'b0,1'b0,R,8'h00,1'b0,8'h00,4'd2},  // 6  R2 flow-through
    '{1'b0,1'b0,W,8'hB1,1'b1,8'hB1,4'd2},  // 7  R2 same-cycle word
    '{1'b0,1'b0,R,8'h55,1'b0,8'h00,4'd5},  // 8  R5 write slot off
    '{1'b0,1'b0,D,8'hB2,1'b1,8'hB2,4'd2},  // 9  R2
    '{1'b0,1'b1,D,8'h66,1'b0,8'h00,4'd3},  // 10 R3 off right after deselect
    '{1'b0,1'b1,D,8'h00,1'b0,8'h00,4'd3},  // 11
    '{1'b0,1'b1,D,8'h00,1'b0,8'h00,4'd3},  // 12
    '{1'b0,1'b1,R,8'h00,1'b0,8'h00,4'd4},  // 13 R4 flow-through DCD
    '{1'b0,1'b1,D,8'hC1,1'b1,8'hC1,4'd2},  // 14 R2
    '{1'b0,1'b1,D,8'h77,1'b1,8'hC1,4'd4},  // 15 R4 extra slot holds word
    '{1'b1,1'b1,D,8'h00,1'b0,8'h00,4'd4},  // 16 R4 off
    '{1'b1,1'b1,D,8'h00,1'b0,8'h00,4'd4},  // 17
    '{1'b1,1'b1,D,8'h00,1'b0,8'h00,4'd4},  // 18
    '{1'b1,1'b1,R,8'h00,1'b0,8'h00,4'd1},  // 19 R1 pipeline DCD
    '{1'b1,1'b1,R,8'hD1,1'b0,8'h00,4'd1},  // 20
    '{1'b1,1'b1,D,8'hD2,1'b1,8'hD1,4'd1},  // 21
    '{1'b1,1'b1,D,8'h00,1'b1,8'hD2,4'd1},  // 22
    '{1'b1,1'b1,D,8'h88,1'b1,8'hD2,4'd4},  // 23 R4 extension
    '{1'b1,1'b1,D,8'h00,1'b0,8'h00,4'd4},  // 24
    '{1'b0,1'b0,R,8'h00,1'b0,8'h00,4'd9},  // 25 R9 mode change mid-burst
    '{1'b0,1'b0,R,8'hE1,1'b0,8'h00,4'd9},  // 26 R9 still pipelined
    '{1'b0,1'b0,D,8'hE2,1'b1,8'hE1,4'd9},  // 27
    '{1'b0,1'b0,D,8'h00,1'b1,8'hE2,4'd9},  // 28
    '{1'b0,1'b0,D,8'h00,1'b1,8'hE2,4'd9},  // 29 R9 still DCD
    '{1'b0,1'b0,D,8'h00,1'b0,8'h00,4'd9},  // 30
    '{1'b0,1'b0,R,8'h00,1'b0,8'h00,4'd9},  // 31 R9 new mode now active
    '{1'b0,1'b0,D,8'hF1,1'b1,8'hF1,4'd9},  // 32
    '{1'b0,1'b0,D,8'h00,1'b0,8'h00,4'd3}   // 33 R3
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cmd_i = D;
  logic [DW-1:0] rdata_i = '0;
  logic pipe_sel_i = 1'b1, dcd_sel_i = 1'b0, oe_n_i = 1'b0, sleep_i = 1'b0;
  logic [DW-1:0] dq_o;
  logic dq_oe_o;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sram_rdout_ctl #(.DW(DW)) u_sram_rdout_ctl (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .rdata_i(rdata_i),
    .pipe_sel_i(pipe_sel_i), .dcd_sel_i(dcd_sel_i), .oe_n_i(oe_n_i),
    .sleep_i(sleep_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  task automatic chk_oe(input string tag, input logic exp);
    n_run++;
    if (dq_oe_o !== exp) begin
      n_fail++;
      $display("FAIL %s: dq_oe_o=%0b expected %0b", tag, dq_oe_o, exp);
    end
  endtask

  task automatic chk_dq(input string tag, input logic [7:0] exp);
    n_run++;
    if (dq_o !== {{(DW-8){1'b0}}, exp}) begin
      n_fail++;
      $display("FAIL %s: dq_o=%0h expected %0h", tag, dq_o, exp);
    end
  endtask

  task automatic put(input logic [1:0] c, input logic [7:0] d);
    cmd_i = c;
    rdata_i = {{(DW-8){1'b0}}, d};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_oe("R8 off during reset", 1'b0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      pipe_sel_i = VEC[i].pipe;
      dcd_sel_i  = VEC[i].dcd;
      put(VEC[i].cmd, VEC[i].rd);
      #1;
      chk_oe($sformatf("R%0d row %0d oe", VEC[i].req, i), VEC[i].oe);
      if (VEC[i].oe) chk_dq($sformatf("R%0d row %0d dq", VEC[i].req, i), VEC[i].dq);
      @(negedge clk);
    end

    // R6: asynchronous output enable, flow-through SCD active
    put(R, 8'h00); @(negedge clk);
    put(D, 8'h3C); #1;
    chk_oe("R6 driving before oe_n", 1'b1);
    chk_dq("R6 data", 8'h3C);
    oe_n_i = 1'b1; #0.5;
    chk_oe("R6 oe_n high mid-cycle", 1'b0);
    oe_n_i = 1'b0; #0.5;
    chk_oe("R6 oe_n low again", 1'b1);
    @(negedge clk);

    // R7: sleep gates drivers and masks commands
    put(R, 8'h00); @(negedge clk);
    put(D, 8'h4D); #1;
    chk_oe("R7 driving before sleep", 1'b1);
    sleep_i = 1'b1; #0.5;
    chk_oe("R7 sleep mid-cycle", 1'b0);
    sleep_i = 1'b0;
    @(negedge clk);
    sleep_i = 1'b1; put(R, 8'h00); @(negedge clk);
    sleep_i = 1'b0; put(D, 8'h5E); #1;
    chk_oe("R7 read during sleep ignored", 1'b0);
    @(negedge clk); #1;
    chk_oe("R7 read during sleep ignored, next slot", 1'b0);
    @(negedge clk);

    // R8: reset clears in-flight read and restores default modes
    pipe_sel_i = 1'b0; dcd_sel_i = 1'b0;
    put(R, 8'h00); @(negedge clk);
    rst = 1'b1; put(D, 8'h11); @(negedge clk); #1;
    chk_oe("R8 in-flight read cleared", 1'b0);
    @(negedge clk);
    rst = 1'b0; put(R, 8'h00); @(negedge clk);
    put(D, 8'h6F); #1;
    chk_oe("R8 default pipeline, no flow-through word", 1'b0);
    @(negedge clk);
    put(D, 8'h00); #1;
    chk_oe("R8 default pipeline word", 1'b1);
    chk_dq("R8 default pipeline word", 8'h6F);
    @(negedge clk); #1;
    chk_oe("R8 default single-cycle deselect", 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule